// File: doc/BRIEF.md
# Dual-Pipeline Instruction Steering

This block sits between an in-order fetch queue and two execution pipes, called X and Y. Each cycle it looks at the two oldest decoded instructions. Each one carries a valid bit and a two-bit class code. Using the class codes and a ready signal from each pipe, the block decides three things: which pipe gets which instruction, whether the two instructions issue together, and how many queue entries the fetch side should pop. All of these results are combinational in the same cycle.

There are four classes. Plain instructions may go to either pipe. Branch and floating-point instructions must use X, but a plain younger instruction may still ride along in Y. An exclusive instruction is a multi-access operation that needs the hardware of both pipes. It issues alone in X, and only when both pipes are ready. After an exclusive instruction issues, the block stops issuing until it sees a completion pulse from the execution side. Instructions are never reordered: the younger slot can only issue in the same cycle as the older slot, and only into Y.

The controller has two states:
- `ST_FLOW` is the normal issue state.
- `ST_HOLD` means an exclusive instruction is in flight.

There are two transitions:
- `START_EXCL` (FLOW to HOLD) happens when an exclusive instruction issues.
- `EXCL_DONE` (HOLD to FLOW) happens when the completion pulse arrives.

Top module: `pipe_steer`

## Requirements
- R1: After reset the block is in the flowing state. With slot 0 invalid, nothing issues and pop_count is 0, even if slot 1 is valid.
- R2: Class code values are 00 plain, 01 branch, 10 floating point and 11 exclusive. A branch or floating-point instruction is never issued to Y, and it issues to X only when x_ready is 1.
- R3: A branch or floating-point instruction in slot 0 that issues to X is paired with slot 1 in Y when slot 1 is valid and plain and y_ready is 1. In that case y_slot is 1 and pop_count is 2.
- R4: A plain instruction in slot 0 goes to X when x_ready is 1. If x_ready is 0 and y_ready is 1, it goes to Y with y_slot 0 and pop_count 1.
- R5: Two plain instructions issue together when both pipes are ready: slot 0 to X, slot 1 to Y.
- R6: A slot 1 instruction of class branch, floating point or exclusive never issues in the same cycle as slot 0. Slot 0 then issues alone.
- R7: An exclusive instruction in slot 0 issues to X only when both x_ready and y_ready are 1. It issues with no Y partner and pop_count 1.
- R8: Once an exclusive instruction issues, nothing issues until excl_done is seen. Nothing issues in the cycle that carries excl_done either, and issue resumes in the following cycle.
- R9: pop_count always equals the number of instructions issued in that cycle. Slot 1 never issues unless slot 0 issues to X in the same cycle.
- R10: excl_done has no effect while no exclusive instruction is in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot0_valid | input | 1 | Older queue entry is present |
| slot0_class | input | 2 | Class code of the older entry |
| slot1_valid | input | 1 | Younger queue entry is present |
| slot1_class | input | 2 | Class code of the younger entry |
| x_ready | input | 1 | X pipe can accept an instruction |
| y_ready | input | 1 | Y pipe can accept an instruction |
| excl_done | input | 1 | Pulse: the exclusive instruction in flight has completed |
| x_issue | output | 1 | Slot 0 is issued to X this cycle |
| y_issue | output | 1 | An instruction is issued to Y this cycle |
| y_slot | output | 1 | Which slot feeds Y (0 older, 1 younger) |
| pop_count | output | 2 | Number of queue entries consumed this cycle |

## Verification
Every issue decision and pop_count is combinational from the inputs and the current state, so each result is due in the same cycle its stimulus is applied. The bench drives inputs just after a rising edge and compares at the following falling edge. The effect of an exclusive issue or of excl_done shows up only after the next rising edge, through the HOLD state. The bench's reference model therefore advances its own in-flight flag at each rising edge, after the comparison for that cycle is done.

// File: rtl/steer_pkg.sv
package steer_pkg;

    localparam int CLS_W   = 2;
    localparam int SLOTS   = 2;
    localparam int POP_W   = $clog2(SLOTS + 1);

    typedef enum logic [CLS_W-1:0] {
        CLS_PLAIN  = 2'b00,
        CLS_BRANCH = 2'b01,
        CLS_FLOAT  = 2'b10,
        CLS_EXCL   = 2'b11
    } cls_e;

    typedef enum logic {
        ST_FLOW = 1'b0,
        ST_HOLD = 1'b1
    } st_e;

    typedef struct packed {
        logic valid;
        logic any_pipe;
        logic x_only;
        logic excl;
    } slot_attr_t;

endpackage

// File: rtl/steer_slot_dec.sv
module steer_slot_dec
    import steer_pkg::*;
(
    input  logic             valid,
    input  logic [CLS_W-1:0] cls,
    output slot_attr_t       attr
);

    cls_e kind;

    always_comb begin
        kind          = cls_e'(cls);
        attr          = '0;
        attr.valid    = valid;
        unique case (kind)
            CLS_PLAIN:  attr.any_pipe = valid;
            CLS_BRANCH: attr.x_only   = valid;
            CLS_FLOAT:  attr.x_only   = valid;
            CLS_EXCL:   attr.excl     = valid;
            default:    attr          = '0;
        endcase
    end

endmodule

// File: rtl/steer_pair_rule.sv
module steer_pair_rule
    import steer_pkg::*;
(
    input  logic       enable,
    input  slot_attr_t older,
    input  slot_attr_t younger,
    input  logic       x_ready,
    input  logic       y_ready,
    output logic       x_go,
    output logic       y_go,
    output logic       y_pick,
    output logic       start_excl
);

    logic older_to_x;
    logic older_to_y;
    logic pair_ok;

    always_comb begin
        // Older entry takes X; exclusive work also needs Y idle.
        older_to_x = enable && older.valid && x_ready && (!older.excl || y_ready);
        // Plain older entry falls back to Y when X is busy.
        older_to_y = enable && older.any_pipe && !x_ready && y_ready;
        // Only a plain younger entry may ride along, and only beside a non-exclusive X issue.
        pair_ok    = older_to_x && !older.excl && younger.any_pipe && y_ready;

        x_go       = older_to_x;
        y_go       = older_to_y || pair_ok;
        y_pick     = pair_ok;
        start_excl = older_to_x && older.excl;
    end

endmodule

// File: rtl/pipe_steer.sv
module pipe_steer
    import steer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot0_valid,
    input  logic [CLS_W-1:0] slot0_class,
    input  logic             slot1_valid,
    input  logic [CLS_W-1:0] slot1_class,
    input  logic             x_ready,
    input  logic             y_ready,
    input  logic             excl_done,
    output logic             x_issue,
    output logic             y_issue,
    output logic             y_slot,
    output logic [POP_W-1:0] pop_count
);

    logic [SLOTS-1:0]             v_arr;
    logic [SLOTS-1:0][CLS_W-1:0]  c_arr;
    slot_attr_t [SLOTS-1:0]       attr;

    assign v_arr = {slot1_valid, slot0_valid};
    assign c_arr = {slot1_class, slot0_class};

    for (genvar s = 0; s < SLOTS; s++) begin : g_dec
        steer_slot_dec u_dec (
            .valid (v_arr[s]),
            .cls   (c_arr[s]),
            .attr  (attr[s])
        );
    end

    st_e  state, state_nx;
    logic flow_en;
    logic x_go, y_go, y_pick, start_excl;

    steer_pair_rule u_rule (
        .enable     (flow_en),
        .older      (attr[0]),
        .younger    (attr[1]),
        .x_ready    (x_ready),
        .y_ready    (y_ready),
        .x_go       (x_go),
        .y_go       (y_go),
        .y_pick     (y_pick),
        .start_excl (start_excl)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FLOW;
        else        state <= state_nx;
    end

    // Next state: START_EXCL and EXCL_DONE transitions.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FLOW: if (start_excl) state_nx = ST_HOLD;
            ST_HOLD: if (excl_done)  state_nx = ST_FLOW;
            default: state_nx = ST_FLOW;
        endcase
    end

    // Outputs.
    always_comb begin
        flow_en   = 1'b0;
        x_issue   = 1'b0;
        y_issue   = 1'b0;
        y_slot    = 1'b0;
        pop_count = '0;
        unique case (state)
            ST_FLOW: begin
                flow_en   = 1'b1;
                x_issue   = x_go;
                y_issue   = y_go;
                y_slot    = y_pick;
                pop_count = POP_W'(x_go) + POP_W'(y_go);
            end
            ST_HOLD: begin
                flow_en   = 1'b0;
            end
            default: begin
                flow_en   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/steer_checker.sv
module steer_checker
    import steer_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             slot0_valid,
    input logic [CLS_W-1:0] slot0_class,
    input logic             slot1_valid,
    input logic [CLS_W-1:0] slot1_class,
    input logic             x_ready,
    input logic             y_ready,
    input logic             excl_done,
    input logic             x_issue,
    input logic             y_issue,
    input logic             y_slot,
    input logic [POP_W-1:0] pop_count
);

    logic [CLS_W-1:0] y_cls;
    logic             excl_go;
    assign y_cls   = y_slot ? slot1_class : slot0_class;
    assign excl_go = x_issue && slot0_class == CLS_EXCL;

    p_y_plain_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        y_issue |-> y_cls == CLS_PLAIN);

    p_x_needs_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        x_issue |-> x_ready && slot0_valid);

    p_excl_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
        excl_go |-> !y_issue && y_ready);

    p_hold_after_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        excl_go |=> !x_issue && !y_issue);

    p_younger_in_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (y_issue && y_slot) |-> x_issue && slot1_valid);

    p_pop_matches_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop_count == POP_W'(x_issue) + POP_W'(y_issue));

    p_idle_no_slot0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !slot0_valid |-> pop_count == '0);

endmodule

bind pipe_steer steer_checker u_chk (.*);

// File: tb/pipe_steer_test.sv
module pipe_steer_test;
    import steer_pkg::*;

    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       s0v, s1v, xr, yr, done;
    logic [1:0] s0c, s1c;
    logic       x_issue, y_issue, y_slot;
    logic [1:0] pop_count;

    int errors = 0;
    int checks = 0;
    bit busy   = 1'b0;
    bit finished = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    pipe_steer uut (
        .clk(clk), .rst_n(rst_n),
        .slot0_valid(s0v), .slot0_class(s0c),
        .slot1_valid(s1v), .slot1_class(s1c),
        .x_ready(xr), .y_ready(yr), .excl_done(done),
        .x_issue(x_issue), .y_issue(y_issue), .y_slot(y_slot),
        .pop_count(pop_count)
    );

    // Reference: {x, y, yslot, pop[1:0]}
    function automatic logic [4:0] model(bit b, logic v0, logic [1:0] c0,
                                         logic v1, logic [1:0] c1,
                                         logic rx, logic ry);
        logic x, y, ys;
        x = 0; y = 0; ys = 0;
        if (!b && v0) begin
            if (c0 == 2'b11) begin
                x = rx && ry;
            end else if (c0 == 2'b00 && !rx) begin
                y = ry;
            end else begin
                x = rx;
                if (x && v1 && c1 == 2'b00 && ry) begin
                    y = 1; ys = 1;
                end
            end
        end
        return {x, y, ys, 2'(x) + 2'(y)};
    endfunction

    task automatic step(string req, logic v0, logic [1:0] c0, logic v1,
                        logic [1:0] c1, logic rx, logic ry, logic d);
        logic [4:0] exp;
        s0v = v0; s0c = c0; s1v = v1; s1c = c1; xr = rx; yr = ry; done = d;
        exp = model(busy, v0, c0, v1, c1, rx, ry);
        @(negedge clk);
        checks++;
        if ({x_issue, y_issue, y_slot, pop_count} !== exp) begin
            errors++;
            $display("FAIL %s: got x=%b y=%b ys=%b pop=%0d expected x=%b y=%b ys=%b pop=%0d",
                     req, x_issue, y_issue, y_slot, pop_count,
                     exp[4], exp[3], exp[2], exp[1:0]);
        end
        @(posedge clk);
        if (busy && d) busy = 1'b0;
        else if (!busy && exp[4] && c0 == 2'b11) busy = 1'b1;
        #1;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; s0v = 0; s1v = 0; s0c = 0; s1c = 0; xr = 0; yr = 0; done = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 idle and younger ignored without older
        step("R1", 0, 2'b00, 1, 2'b00, 1, 1, 0);
        step("R1", 1, 2'b00, 0, 2'b00, 1, 1, 0);
        // R10 excl_done while flowing has no effect
        step("R10", 1, 2'b00, 1, 2'b00, 1, 1, 1);
        // R5 two plain
        step("R5", 1, 2'b00, 1, 2'b00, 1, 1, 0);
        // R4 plain to Y when X busy
        step("R4", 1, 2'b00, 1, 2'b00, 0, 1, 0);
        // R3 branch pairs with plain, float pairs too
        step("R3", 1, 2'b01, 1, 2'b00, 1, 1, 0);
        step("R3", 1, 2'b10, 1, 2'b00, 1, 1, 0);
        // R2 branch waits when X not ready
        step("R2", 1, 2'b01, 1, 2'b00, 0, 1, 0);
        // R6 younger X-only / exclusive not paired
        step("R6", 1, 2'b00, 1, 2'b10, 1, 1, 0);
        step("R6", 1, 2'b01, 1, 2'b11, 1, 1, 0);
        // R7 exclusive needs both ready
        step("R7", 1, 2'b11, 1, 2'b00, 1, 0, 0);
        step("R7", 1, 2'b11, 1, 2'b00, 1, 1, 0);
        // R8 hold until done, nothing in done cycle, resume after
        step("R8", 1, 2'b00, 1, 2'b00, 1, 1, 0);
        step("R8", 1, 2'b00, 1, 2'b00, 1, 1, 1);
        step("R8", 1, 2'b00, 1, 2'b00, 1, 1, 0);
        // R9 random mix
        void'($urandom(32'd7));
        for (int i = 0; i < 4000; i++) begin
            step("R9",
                 ($urandom % 10) < 8, 2'($urandom),
                 ($urandom % 10) < 7, 2'($urandom),
                 ($urandom % 4) != 0, ($urandom % 4) != 0,
                 ($urandom % 4) == 0);
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule